// File: doc/BRIEF.md
# Programmable Down-Counter Timer Channel

This block is one timer channel that counts down by one on each enabled tick of a selectable prescaler. The prescaler divides the clock by 1, 16 or 256. The channel can run free and wrap, reload from a load register, or stop after a single expiry. The counter works at 16 or 32 bits. In 16-bit mode the upper halves of the count and the load value are kept unchanged, and a read returns them.

Software-side logic outside the block decodes the bus. It hands the channel a shared write-data word and one strobe per register: control, immediate load, background load and interrupt clear. The current control byte, load value and count are always visible on read ports. The channel also drives a raw expiry flag and a copy of that flag gated by the interrupt-enable bit.

Top module: `tmr_channel`

## Requirements
- R1: The control byte decodes as follows: bit 0 stop after one expiry, bit 1 width (1 = 32-bit, 0 = 16-bit), bits 3:2 prescale, bit 5 interrupt enable, bit 6 mode (1 = reload from load, 0 = free wrap) and bit 7 enable. Bit 4 always reads 0, so a write of 0xFF reads back as 0xEF.
- R2: After reset the control byte is 0x20, the load value is 0, the count is 0xFFFFFFFF and both interrupt outputs are low.
- R3: Prescale code 00 gives one tick per clock, 01 one tick every 16 clocks, and 10 or 11 one tick every 256 clocks. A write that changes the prescale field restarts the divider, so the first decrement lands exactly one full period after that write.
- R4: In free-wrap mode a tick at a zero count loads all ones of the active width: 0xFFFF in the low half in 16-bit mode, or 0xFFFFFFFF in 32-bit mode.
- R5: In reload mode a tick at a zero count copies the load value into the count. A background-load write changes only the load value, and the new value takes effect at the next reload.
- R6: A load write replaces the load value and the count on the same edge. A tick that falls in the same cycle is dropped.
- R7: In 16-bit mode only bits 15:0 of the count decrement, wrap or reload. Bits 31:16 of the count and the load value are kept and read back.
- R8: In single-expiry mode the count halts at zero. A nonzero load write while enabled makes it count again.
- R9: The raw flag is set only when a tick decrements the count onto zero. A count that reaches zero through a load or a reload does not set it. When an expiry and an interrupt-clear strobe fall in the same cycle, the flag ends up set.
- R10: An interrupt-clear strobe clears the raw flag. The masked output equals the raw flag ANDed with control bit 5.
- R11: In reload mode a load value of zero keeps the count at zero and raises no interrupt.
- R12: While control bit 7 is 0 the count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrData | input | 32 | Write data shared by all register strobes |
| ctrlWr | input | 1 | Write the low byte of wrData into control |
| loadWr | input | 1 | Immediate load: set the load value and the count |
| bgLoadWr | input | 1 | Background load: set the load value only |
| intClrWr | input | 1 | Clear the raw interrupt flag |
| ctrlRd | output | 8 | Current control byte |
| loadRd | output | 32 | Current load value |
| valueRd | output | 32 | Current count |
| rawInt | output | 1 | Raw expiry flag |
| maskedInt | output | 1 | Raw flag gated by interrupt enable |

## Verification
Two pairs of events can meet on one edge. A decrement onto zero can coincide with an interrupt-clear strobe, and a tick can coincide with a load write. The bench lines up the first pair by loading 2 with a divide-by-1 prescale and issuing the clear on the second tick; the flag must read 1 afterwards, and a second clear must then drop it. For the second pair, it writes a new load value while the counter ticks on every clock; the count must show exactly the written value, with no decrement taken on that edge.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int CTRL_W = 8;
  localparam int B_ONESHOT = 0;
  localparam int B_SIZE    = 1;
  localparam int B_PRE_LO  = 2;
  localparam int B_INTEN   = 5;
  localparam int B_MODE    = 6;
  localparam int B_EN      = 7;
  localparam logic [CTRL_W-1:0] CTRL_VALID = 8'hEF;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h20;

  typedef struct packed {
    logic tick;
    logic loadNow;
    logic bgLoad;
    logic intClr;
    logic is32;
    logic periodic;
    logic oneShot;
  } tmr_strobe_t;
endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
  parameter int DIV_SHIFT = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       preTick
);
  localparam int PRE_W = 2 * DIV_SHIFT;
  localparam logic [PRE_W-1:0] MID_MAX = PRE_W'((1 << DIV_SHIFT) - 1);

  logic [PRE_W-1:0] divCnt;
  logic [PRE_W-1:0] divMax;

  always_comb begin
    case (sel)
      2'b00:   divMax = '0;
      2'b01:   divMax = MID_MAX;
      default: divMax = '1;
    endcase
  end

  assign preTick = (divCnt == divMax);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        divCnt <= '0;
    else if (restart) divCnt <= '0;
    else if (preTick) divCnt <= '0;
    else              divCnt <= divCnt + 1'b1;
  end

  // R3: after a restart the next cycle cannot tick unless dividing by 1
  a_r3_restart_quiet: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (sel == 2'b00) || !preTick);
endmodule

// File: rtl/tmr_ctrl.sv
`timescale 1ns/1ps
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CTRL_W-1:0] wrByte,
  input  logic              ctrlWr,
  input  logic              loadWr,
  input  logic              bgLoadWr,
  input  logic              intClrWr,
  input  logic              preTick,
  input  logic              rawInt,
  output logic              preRestart,
  output logic [1:0]        preSel,
  output logic [CTRL_W-1:0] ctrlQ,
  output logic              maskedInt,
  output tmr_strobe_t       strb
);
  logic [CTRL_W-1:0] ctrlNew;

  assign ctrlNew    = wrByte & CTRL_VALID;
  assign preSel     = ctrlQ[B_PRE_LO +: 2];
  assign preRestart = ctrlWr && (ctrlNew[B_PRE_LO +: 2] != ctrlQ[B_PRE_LO +: 2]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       ctrlQ <= CTRL_RESET;
    else if (ctrlWr) ctrlQ <= ctrlNew;
  end

  always_comb begin
    strb.tick     = ctrlQ[B_EN] && preTick;
    strb.loadNow  = loadWr;
    strb.bgLoad   = bgLoadWr;
    strb.intClr   = intClrWr;
    strb.is32     = ctrlQ[B_SIZE];
    strb.periodic = ctrlQ[B_MODE];
    strb.oneShot  = ctrlQ[B_ONESHOT];
  end

  assign maskedInt = rawInt && ctrlQ[B_INTEN];

  // R1: control holds its value between writes
  a_r1_ctrl_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWr |=> ctrlQ == $past(ctrlQ));
  // R10: the masked output never stands without the raw flag
  a_r10_mask_implies_raw: assert property (@(posedge clk) disable iff (!rstN)
    maskedInt |-> rawInt);
endmodule

// File: rtl/tmr_datapath.sv
`timescale 1ns/1ps
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int HALF_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmr_strobe_t      strb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] valQ,
  output logic [CNT_W-1:0] loadQ,
  output logic             rawQ
);
  localparam int UP_W = CNT_W - HALF_W;

  logic [CNT_W-1:0]  valNext;
  logic [HALF_W-1:0] lowDec;
  logic [UP_W-1:0]   upKeep;
  logic              curZero;
  logic              curOne;
  logic              hitZero;
  logic              stepEn;

  assign upKeep  = valQ[CNT_W-1:HALF_W];
  assign lowDec  = valQ[HALF_W-1:0] - 1'b1;
  assign curZero = strb.is32 ? (valQ == '0) : (valQ[HALF_W-1:0] == '0);
  assign curOne  = strb.is32 ? (valQ == CNT_W'(1)) : (valQ[HALF_W-1:0] == HALF_W'(1));
  assign stepEn  = strb.tick && !strb.loadNow;

  always_comb begin
    valNext = valQ;
    hitZero = 1'b0;
    if (curZero) begin
      if (strb.oneShot)       valNext = valQ;
      else if (strb.periodic) valNext = strb.is32 ? loadQ : {upKeep, loadQ[HALF_W-1:0]};
      else                    valNext = strb.is32 ? '1 : {upKeep, {HALF_W{1'b1}}};
    end else begin
      valNext = strb.is32 ? (valQ - 1'b1) : {upKeep, lowDec};
      hitZero = curOne;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valQ  <= '1;
      loadQ <= '0;
    end else if (strb.loadNow) begin
      valQ  <= wrData;
      loadQ <= wrData;
    end else begin
      if (strb.bgLoad) loadQ <= wrData;
      if (stepEn)      valQ  <= valNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    rawQ <= 1'b0;
    else if (stepEn && hitZero)   rawQ <= 1'b1;
    else if (strb.intClr)         rawQ <= 1'b0;
  end

  // R6: an immediate load lands on the count regardless of the tick
  a_r6_load_now: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadNow |=> valQ == $past(wrData));
  // R7: a 16-bit step leaves the upper half alone
  a_r7_upper_kept: assert property (@(posedge clk) disable iff (!rstN)
    stepEn && !strb.is32 |=> valQ[CNT_W-1:HALF_W] == $past(valQ[CNT_W-1:HALF_W]));
  // R8: single-expiry mode holds at zero
  a_r8_oneshot_hold: assert property (@(posedge clk) disable iff (!rstN)
    stepEn && strb.oneShot && curZero |=> valQ == $past(valQ));
  // R4: free wrap fills the low half with ones
  a_r4_wrap_ones: assert property (@(posedge clk) disable iff (!rstN)
    stepEn && !strb.oneShot && !strb.periodic && curZero |=> valQ[HALF_W-1:0] == '1);
  // R9: the flag only rises with a zero low half on the count
  a_r9_rise_on_zero: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rawQ) |-> valQ[HALF_W-1:0] == '0);
  // R10: a clear with no competing expiry drops the flag
  a_r10_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.intClr && !(stepEn && hitZero) |=> !rawQ);
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int HALF_W    = 16,
  parameter int DIV_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              ctrlWr,
  input  logic              loadWr,
  input  logic              bgLoadWr,
  input  logic              intClrWr,
  output logic [CTRL_W-1:0] ctrlRd,
  output logic [CNT_W-1:0]  loadRd,
  output logic [CNT_W-1:0]  valueRd,
  output logic              rawInt,
  output logic              maskedInt
);
  tmr_strobe_t strb;
  logic        preTick;
  logic        preRestart;
  logic [1:0]  preSel;

  tmr_prescaler #(.DIV_SHIFT(DIV_SHIFT)) uPre (
    .clk(clk), .rstN(rstN), .restart(preRestart), .sel(preSel), .preTick(preTick)
  );

  tmr_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .wrByte(wrData[CTRL_W-1:0]), .ctrlWr(ctrlWr),
    .loadWr(loadWr), .bgLoadWr(bgLoadWr), .intClrWr(intClrWr),
    .preTick(preTick), .rawInt(rawInt), .preRestart(preRestart), .preSel(preSel),
    .ctrlQ(ctrlRd), .maskedInt(maskedInt), .strb(strb)
  );

  tmr_datapath #(.CNT_W(CNT_W), .HALF_W(HALF_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .valQ(valueRd), .loadQ(loadRd), .rawQ(rawInt)
  );
endmodule

// File: tb/tb_tmr_channel.sv
`timescale 1ns/1ps
module tb_tmr_channel;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] wrData = '0;
  logic        ctrlWr = 1'b0, loadWr = 1'b0, bgLoadWr = 1'b0, intClrWr = 1'b0;
  logic [7:0]  ctrlRd;
  logic [31:0] loadRd, valueRd;
  logic        rawInt, maskedInt;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tmr_channel dut (
    .clk(clk), .rstN(rstN), .wrData(wrData), .ctrlWr(ctrlWr), .loadWr(loadWr),
    .bgLoadWr(bgLoadWr), .intClrWr(intClrWr), .ctrlRd(ctrlRd), .loadRd(loadRd),
    .valueRd(valueRd), .rawInt(rawInt), .maskedInt(maskedInt)
  );

  localparam int NV = 10;
  localparam logic [7:0]  V_CTRL [NV] = '{8'hA2, 8'hA2, 8'hA2, 8'hA0, 8'hE2,
                                          8'hE0, 8'hA3, 8'hE2, 8'h22, 8'hA1};
  localparam logic [31:0] V_LOAD [NV] = '{32'd5, 32'd3, 32'd2, 32'h1234_0002, 32'd3,
                                          32'hABCD_0001, 32'd2, 32'd0, 32'd7, 32'h0005_0001};
  localparam int          V_N    [NV] = '{3, 3, 4, 4, 5, 3, 6, 5, 5, 4};

  function automatic string vecReq(input int i);
    case (i)
      0, 1:    return "R4";
      2:       return "R4/R9";
      3:       return "R7";
      4:       return "R5";
      5:       return "R7/R5";
      6, 9:    return "R8";
      7:       return "R11";
      default: return "R12";
    endcase
  endfunction

  function automatic void model(input logic [7:0] c, input logic [31:0] ld, input int n,
                                output logic [31:0] v, output logic r);
    logic is32;
    logic zero;
    v = ld; r = 1'b0; is32 = c[1];
    if (!c[7]) return;
    for (int i = 0; i < n; i++) begin
      zero = is32 ? (v == 0) : (v[15:0] == 0);
      if (zero) begin
        if (c[0]) v = v;
        else if (c[6]) v = is32 ? ld : {v[31:16], ld[15:0]};
        else v = is32 ? 32'hFFFF_FFFF : {v[31:16], 16'hFFFF};
      end else begin
        v = is32 ? v - 1 : {v[31:16], v[15:0] - 16'd1};
        if (is32 ? (v == 0) : (v[15:0] == 0)) r = 1'b1;
      end
    end
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic wrCtrl(input logic [7:0] d);
    wrData = {24'h0, d}; ctrlWr = 1'b1; @(negedge clk); ctrlWr = 1'b0;
  endtask
  task automatic wrLoad(input logic [31:0] d);
    wrData = d; loadWr = 1'b1; @(negedge clk); loadWr = 1'b0;
  endtask
  task automatic wrBg(input logic [31:0] d);
    wrData = d; bgLoadWr = 1'b1; @(negedge clk); bgLoadWr = 1'b0;
  endtask
  task automatic clrInt();
    intClrWr = 1'b1; @(negedge clk); intClrWr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] ev;
    logic er;
    logic [31:0] held;
    doReset();
    // R2 reset state
    chk("R2 ctrl", 32'(ctrlRd), 32'h20);
    chk("R2 load", loadRd, 32'h0);
    chk("R2 value", valueRd, 32'hFFFF_FFFF);
    chk("R2 raw", 32'(rawInt), 32'h0);
    chk("R2 masked", 32'(maskedInt), 32'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      doReset();
      wrCtrl(V_CTRL[i] & 8'h7F);
      wrLoad(V_LOAD[i]);
      wrCtrl(V_CTRL[i]);
      repeat (V_N[i]) @(negedge clk);
      model(V_CTRL[i], V_LOAD[i], V_N[i], ev, er);
      chk({vecReq(i), " value"}, valueRd, ev);
      chk({vecReq(i), " raw"}, 32'(rawInt), 32'(er));
      chk("R10 masked", 32'(maskedInt), 32'(er & V_CTRL[i][5]));
    end

    // R1 reserved bit
    doReset();
    wrCtrl(8'hFF);
    chk("R1 ctrl readback", 32'(ctrlRd), 32'hEF);

    // R3 prescale 16 then reserved code as 256
    doReset();
    wrLoad(32'd100);
    wrCtrl(8'hA6);
    repeat (15) @(negedge clk);
    chk("R3 div16 before", valueRd, 32'd100);
    @(negedge clk);
    chk("R3 div16 edge", valueRd, 32'd99);
    wrCtrl(8'hAE);
    held = valueRd;
    repeat (255) @(negedge clk);
    chk("R3 div256 before", valueRd, held);
    @(negedge clk);
    chk("R3 div256 edge", valueRd, held - 1);

    // R5 background load
    doReset();
    wrCtrl(8'h62);
    wrLoad(32'd3);
    wrCtrl(8'hE2);
    wrBg(32'd10);
    chk("R5 bgload keeps count", valueRd, 32'd2);
    chk("R5 bgload value", loadRd, 32'd10);
    repeat (2) @(negedge clk);
    chk("R5 at zero", valueRd, 32'd0);
    @(negedge clk);
    chk("R5 reload new", valueRd, 32'd10);
    // R6 load beats tick
    wrLoad(32'd50);
    chk("R6 load wins", valueRd, 32'd50);
    @(negedge clk);
    chk("R6 then counts", valueRd, 32'd49);

    // R8 restart after expiry
    doReset();
    wrCtrl(8'h23);
    wrLoad(32'd2);
    wrCtrl(8'hA3);
    repeat (4) @(negedge clk);
    chk("R8 halted", valueRd, 32'd0);
    wrLoad(32'd4);
    repeat (2) @(negedge clk);
    chk("R8 restarted", valueRd, 32'd2);

    // R9 load of zero raises nothing
    doReset();
    wrCtrl(8'hA2);
    wrLoad(32'd0);
    chk("R9 load zero raw", 32'(rawInt), 32'h0);
    @(negedge clk);
    chk("R9 wrap no raw", 32'(rawInt), 32'h0);
    chk("R4 wrap32", valueRd, 32'hFFFF_FFFF);

    // R9 expiry and clear on the same edge; R10 masking and clear
    doReset();
    wrCtrl(8'h22);
    wrLoad(32'd2);
    wrCtrl(8'hA2);
    @(negedge clk);
    clrInt();
    chk("R9 set wins value", valueRd, 32'd0);
    chk("R9 set wins raw", 32'(rawInt), 32'h1);
    chk("R10 masked on", 32'(maskedInt), 32'h1);
    wrCtrl(8'h82);
    chk("R10 masked off", 32'(maskedInt), 32'h0);
    chk("R10 raw kept", 32'(rawInt), 32'h1);
    clrInt();
    chk("R10 cleared", 32'(rawInt), 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule